// File: doc/BRIEF.md
# SD Host Register Compatibility Shim

This block sits between a host register bus and a vendor SD host controller register file whose layout departs from the standard SD host register map. Software issues accesses against the standard map. The shim changes each one into the vendor layout. It moves status bits to their standard positions on reads and back on writes. It replaces capability fields and sends clock and signalling controls to a vendor-specific word. It holds a transfer-mode half-word until the command half-word arrives, then writes both as one word. It also restores the card-detect clock enables that a software reset would otherwise clear.

The host accepts one access at a time. `hReq` is taken only while `hReady` is high, and `hWe`, `hAddr`, `hSize` and `hWData` are sampled with it. Size encoding: 0 = byte, 1 = half-word, 2 = word. Sub-word write data and sub-word read data are right-aligned on the 32-bit buses. The vendor side reads combinationally: `vRData` must show the word at `vAddr` in the same cycle that `vRe` is high. Each access has at most one vendor read phase followed by at most one vendor write phase.

Top module: `sd_reg_shim`

## Requirements
- R1: A word read at offset 0x24 returns the following layout, with bits 31:25 as zero:
  - vendor bits 19:0 in bits 19:0;
  - vendor bits 27:24 in bits 23:20;
  - vendor bit 23 in bit 24.
- R2: A word read at offset 0x30 with vendor bit 28 set returns bit 28 clear and bit 25 set. All other bits pass through unchanged.
- R3: A word write to offset 0x34 or 0x38 with bit 25 set stores bit 25 clear and bit 28 set. All other bits are written unchanged.
- R4: A word read at offset 0x40 with bit 20 set returns bit 20 clear and bit 19 set. All other bits pass through unchanged.
- R5: A half-word write to offset 0x0C makes no vendor access. The shim only remembers the value, and `hReady` never drops for it.
- R6: A half-word write to offset 0x0E makes exactly one vendor word write to offset 0x0C. The value is (written half-word << 16) | the last value held by R5.
- R7: A half-word write to offset 0x2C copies its bit 2 into bit 8 of the vendor word at 0xC0 and leaves every other vendor bit as it was.
- R8: A half-word write to offset 0x3E copies its bit 3 into bit 1 of vendor word 0xC0 and keeps its bits 2:0 internally. A half-word read of 0x3E returns vendor bit 1 in bit 3 and the kept bits in bits 2:0. All other bits, including bit 15, read as 0.
- R9: Writes to the block-size half-word at offset 0x04 store bits 14:12 as zero.
- R10: A byte write to offset 0x2F with bit 0 set updates byte lane 3 of word 0x2C and also forces bits 2:0 of that word to 1. With bit 0 clear, only lane 3 changes.
- R11: A byte write to offset 0x28 leaves word bits 3:1 and 31:16 untouched. It writes bit 0 from data bit 0 and bits 9:8 from data bits 4:3, and clears every other bit in 15:4.
- R12: Every other access passes through. A word write stores the value directly. A sub-word write does a read-modify-write of the aligned word at byte lane `hAddr[1:0]`. A sub-word read returns that lane right-aligned.
- R13: Reads return `hRValid` with data one cycle after their vendor read. The busy time after acceptance is one cycle for a read or a plain write, and two cycles for a read-modify-write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hReq | input | 1 | Host access request, taken while hReady is high |
| hWe | input | 1 | Host access is a write |
| hAddr | input | AW | Host byte offset in the standard map |
| hSize | input | 2 | 0 byte, 1 half-word, 2 word |
| hWData | input | 32 | Host write data, right-aligned |
| hReady | output | 1 | Shim idle and able to accept an access |
| hRValid | output | 1 | One-cycle pulse: hRData holds read data |
| hRData | output | 32 | Host read data, right-aligned |
| vRe | output | 1 | Vendor word read strobe |
| vWe | output | 1 | Vendor word write strobe |
| vAddr | output | AW | Vendor word-aligned byte offset |
| vWData | output | 32 | Vendor write word |
| vRData | input | 32 | Vendor word at vAddr, combinational |

## Verification
The hardest case to reach is the deferred transfer-mode value. It never reaches the vendor side on its own. Its effect can only be seen when a later command write carries it, and a second command write must reuse it. The stimulus first loads a marker into vendor word 0x0C and checks after the transfer-mode write that the marker is still there. It then issues two command writes, with no new transfer-mode write between them, and checks both merged words. The read-modify-write cases are reached by placing chosen bit patterns directly in the behavioural register array. This makes bits that the shim must preserve visible in the final vendor word.

// File: rtl/sd_reg_shim_pkg.sv
package sd_reg_shim_pkg;
  localparam int DW = 32;

  localparam logic [7:0] OFF_BLKSIZE  = 8'h04;
  localparam logic [7:0] OFF_XFERMODE = 8'h0C;
  localparam logic [7:0] OFF_CMD      = 8'h0E;
  localparam logic [7:0] OFF_PRESENT  = 8'h24;
  localparam logic [7:0] OFF_HOSTCTL  = 8'h28;
  localparam logic [7:0] OFF_CLKCTL   = 8'h2C;
  localparam logic [7:0] OFF_SWRST    = 8'h2F;
  localparam logic [7:0] OFF_INTSTAT  = 8'h30;
  localparam logic [7:0] OFF_INTEN    = 8'h34;
  localparam logic [7:0] OFF_SIGEN    = 8'h38;
  localparam logic [7:0] OFF_HOSTCTL2 = 8'h3E;
  localparam logic [7:0] OFF_CAPS     = 8'h40;
  localparam logic [7:0] OFF_VENDOR   = 8'hC0;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  typedef enum logic [3:0] {
    K_WR_WORD, K_WR_SUB, K_RD, K_XFERMODE, K_CMD, K_CLKCTL, K_HC2_WR,
    K_HC2_RD, K_BLKSIZE, K_HOSTCTL, K_INTEN, K_SWRST, K_PRESENT,
    K_INTSTAT, K_CAPS
  } accKind_t;

  typedef struct packed {
    logic needRead;
    logic needWrite;
  } accPlan_t;

  typedef struct packed {
    logic capture;
    logic rdPhase;
    logic wrPhase;
  } ctlStrobe_t;
endpackage

// File: rtl/sd_reg_shim_ctrl.sv
module sd_reg_shim_ctrl
  import sd_reg_shim_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       hReq,
  input  accPlan_t   livePlan,
  output logic       hReady,
  output ctlStrobe_t strobe
);
  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} ctlState_t;

  ctlState_t state;
  logic      pendWrite;

  assign hReady         = (state == ST_IDLE);
  assign strobe.capture = hReady && hReq;
  assign strobe.rdPhase = (state == ST_RD);
  assign strobe.wrPhase = (state == ST_WR);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      pendWrite <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (strobe.capture) begin
          pendWrite <= livePlan.needWrite;
          if (livePlan.needRead)       state <= ST_RD;
          else if (livePlan.needWrite) state <= ST_WR;
        end
        ST_RD:   state <= pendWrite ? ST_WR : ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sd_reg_shim_datapath.sv
module sd_reg_shim_datapath
  import sd_reg_shim_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctlStrobe_t    strobe,
  input  logic          hWe,
  input  logic [AW-1:0] hAddr,
  input  logic [1:0]    hSize,
  input  logic [DW-1:0] hWData,
  input  logic [DW-1:0] vRData,
  output accPlan_t      livePlan,
  output logic [AW-1:0] vAddr,
  output logic [DW-1:0] vWData,
  output logic [DW-1:0] hRData,
  output logic          hRValid
);
  localparam int HW = DW / 2;

  accKind_t      liveKind, reqKind;
  logic [AW-1:0] reqAddr;
  logic [1:0]    reqSize;
  logic [DW-1:0] reqData;
  logic [DW-1:0] rdLatch;
  logic [HW-1:0] scratch;
  logic [2:0]    uhsShadow;

  function automatic logic isAt(input logic [AW-1:0] a, input logic [7:0] off);
    return a == AW'(off);
  endfunction

  // live decode of the request offered on the host port
  always_comb begin
    if (hWe) begin
      if (isAt(hAddr, OFF_XFERMODE) && hSize == SZ_HALF)      liveKind = K_XFERMODE;
      else if (isAt(hAddr, OFF_CMD) && hSize == SZ_HALF)      liveKind = K_CMD;
      else if (isAt(hAddr, OFF_CLKCTL) && hSize == SZ_HALF)   liveKind = K_CLKCTL;
      else if (isAt(hAddr, OFF_HOSTCTL2) && hSize == SZ_HALF) liveKind = K_HC2_WR;
      else if (isAt(hAddr, OFF_BLKSIZE) && hSize != SZ_BYTE)  liveKind = K_BLKSIZE;
      else if (isAt(hAddr, OFF_HOSTCTL) && hSize == SZ_BYTE)  liveKind = K_HOSTCTL;
      else if ((isAt(hAddr, OFF_INTEN) || isAt(hAddr, OFF_SIGEN)) && hSize == SZ_WORD)
                                                              liveKind = K_INTEN;
      else if (isAt(hAddr, OFF_SWRST) && hSize == SZ_BYTE)    liveKind = K_SWRST;
      else if (hSize == SZ_WORD)                              liveKind = K_WR_WORD;
      else                                                    liveKind = K_WR_SUB;
    end else begin
      if (isAt(hAddr, OFF_HOSTCTL2) && hSize == SZ_HALF)      liveKind = K_HC2_RD;
      else if (isAt(hAddr, OFF_PRESENT) && hSize == SZ_WORD)  liveKind = K_PRESENT;
      else if (isAt(hAddr, OFF_INTSTAT) && hSize == SZ_WORD)  liveKind = K_INTSTAT;
      else if (isAt(hAddr, OFF_CAPS) && hSize == SZ_WORD)     liveKind = K_CAPS;
      else                                                    liveKind = K_RD;
    end
  end

  always_comb begin
    unique case (liveKind)
      K_XFERMODE:       livePlan = '{needRead: 1'b0, needWrite: 1'b0};
      K_CMD, K_WR_WORD,
      K_INTEN:          livePlan = '{needRead: 1'b0, needWrite: 1'b1};
      K_WR_SUB, K_CLKCTL, K_HC2_WR, K_BLKSIZE, K_HOSTCTL, K_SWRST:
                        livePlan = '{needRead: 1'b1, needWrite: 1'b1};
      default:          livePlan = '{needRead: 1'b1, needWrite: 1'b0};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqKind   <= K_RD;
      reqAddr   <= '0;
      reqSize   <= SZ_WORD;
      reqData   <= '0;
      rdLatch   <= '0;
      scratch   <= '0;
      uhsShadow <= '0;
      hRData    <= '0;
      hRValid   <= 1'b0;
    end else begin
      hRValid <= strobe.rdPhase && !livePlanIsWrite(reqKind);
      if (strobe.capture) begin
        reqKind <= liveKind;
        reqAddr <= hAddr;
        reqSize <= hSize;
        reqData <= hWData;
        if (liveKind == K_XFERMODE) scratch   <= hWData[HW-1:0];
        if (liveKind == K_HC2_WR)   uhsShadow <= hWData[2:0];
      end
      if (strobe.rdPhase) begin
        rdLatch <= vRData;
        hRData  <= readView;
      end
    end
  end

  function automatic logic livePlanIsWrite(input accKind_t k);
    return !(k inside {K_RD, K_HC2_RD, K_PRESENT, K_INTSTAT, K_CAPS});
  endfunction

  // lane placement for sub-word accesses
  logic [4:0]    laneShift;
  logic [DW-1:0] sizeMask, laneMask;
  assign laneShift = {reqAddr[1:0], 3'b000};
  always_comb begin
    unique case (reqSize)
      SZ_BYTE: sizeMask = DW'(8'hFF);
      SZ_HALF: sizeMask = DW'(16'hFFFF);
      default: sizeMask = '1;
    endcase
  end
  assign laneMask = sizeMask << laneShift;

  function automatic logic [DW-1:0] mergeLane(input logic [DW-1:0] oldW,
                                               input logic [DW-1:0] val);
    return (oldW & ~laneMask) | ((val & sizeMask) << laneShift);
  endfunction

  // vendor address
  always_comb begin
    unique case (reqKind)
      K_CMD:                       vAddr = AW'(OFF_XFERMODE);
      K_CLKCTL, K_HC2_WR, K_HC2_RD: vAddr = AW'(OFF_VENDOR);
      default:                     vAddr = {reqAddr[AW-1:2], 2'b00};
    endcase
  end

  // vendor write word
  logic [DW-1:0] hostCtlNew;
  localparam logic [DW-1:0] HOSTCTL_FIELD = 32'h0000_FFF1;
  assign hostCtlNew = {22'b0, reqData[4:3], 7'b0, reqData[0]};

  always_comb begin
    vWData = mergeLane(rdLatch, reqData);
    unique case (reqKind)
      K_WR_WORD: vWData = reqData;
      K_CMD:     vWData = {reqData[HW-1:0], scratch};
      K_CLKCTL:  begin vWData = rdLatch; vWData[8] = reqData[2]; end
      K_HC2_WR:  begin vWData = rdLatch; vWData[1] = reqData[3]; end
      K_BLKSIZE: vWData = mergeLane(rdLatch, reqData & ~DW'(32'h7000));
      K_HOSTCTL: vWData = (rdLatch & ~HOSTCTL_FIELD) | hostCtlNew;
      K_INTEN:   begin
        vWData = reqData;
        if (reqData[25]) begin vWData[25] = 1'b0; vWData[28] = 1'b1; end
      end
      K_SWRST:   vWData = mergeLane(rdLatch, reqData) | (reqData[0] ? DW'(3'b111) : '0);
      default:   ;
    endcase
  end

  // host read view of the vendor word
  logic [DW-1:0] readView;
  always_comb begin
    unique case (reqKind)
      K_PRESENT: readView = {7'b0, vRData[23], vRData[27:24], vRData[19:0]};
      K_INTSTAT: begin
        readView = vRData;
        if (vRData[28]) begin readView[28] = 1'b0; readView[25] = 1'b1; end
      end
      K_CAPS: begin
        readView = vRData;
        if (vRData[20]) begin readView[20] = 1'b0; readView[19] = 1'b1; end
      end
      K_HC2_RD:  readView = {28'b0, vRData[1], uhsShadow};
      default:   readView = (vRData >> laneShift) & sizeMask;
    endcase
  end
endmodule

// File: rtl/sd_reg_shim.sv
module sd_reg_shim
  import sd_reg_shim_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          hReq,
  input  logic          hWe,
  input  logic [AW-1:0] hAddr,
  input  logic [1:0]    hSize,
  input  logic [31:0]   hWData,
  output logic          hReady,
  output logic          hRValid,
  output logic [31:0]   hRData,
  output logic          vRe,
  output logic          vWe,
  output logic [AW-1:0] vAddr,
  output logic [31:0]   vWData,
  input  logic [31:0]   vRData
);
  ctlStrobe_t strobe;
  accPlan_t   livePlan;

  sd_reg_shim_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .hReq     (hReq),
    .livePlan (livePlan),
    .hReady   (hReady),
    .strobe   (strobe)
  );

  sd_reg_shim_datapath #(.AW(AW)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .hWe      (hWe),
    .hAddr    (hAddr),
    .hSize    (hSize),
    .hWData   (hWData),
    .vRData   (vRData),
    .livePlan (livePlan),
    .vAddr    (vAddr),
    .vWData   (vWData),
    .hRData   (hRData),
    .hRValid  (hRValid)
  );

  assign vRe = strobe.rdPhase;
  assign vWe = strobe.wrPhase;
endmodule

// File: rtl/sd_reg_shim_chk.sv
module sd_reg_shim_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rstN,
  input logic          hReq,
  input logic          hWe,
  input logic [AW-1:0] hAddr,
  input logic [1:0]    hSize,
  input logic          hReady,
  input logic          hRValid,
  input logic [31:0]   hRData,
  input logic          vRe,
  input logic          vWe,
  input logic [AW-1:0] vAddr,
  input logic [31:0]   vWData
);
  logic [AW-1:0] lastAddr;
  logic [1:0]    lastSize;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastAddr <= '0;
      lastSize <= '0;
    end else if (hReq && hReady) begin
      lastAddr <= hAddr;
      lastSize <= hSize;
    end
  end

  a_r13_rvalid_follows_read: assert property (@(posedge clk) disable iff (!rstN)
    hRValid |-> $past(vRe));

  a_r1_present_top_zero: assert property (@(posedge clk) disable iff (!rstN)
    (hRValid && lastAddr == AW'(8'h24) && lastSize == 2'd2) |-> hRData[31:25] == 7'd0);

  a_r2_no_vendor_dma_bit: assert property (@(posedge clk) disable iff (!rstN)
    (hRValid && lastAddr == AW'(8'h30) && lastSize == 2'd2) |-> !hRData[28]);

  a_r4_no_adma1_seen: assert property (@(posedge clk) disable iff (!rstN)
    (hRValid && lastAddr == AW'(8'h40) && lastSize == 2'd2) |-> !hRData[20]);

  a_r8_hc2_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    (hRValid && lastAddr == AW'(8'h3E) && lastSize == 2'd1) |-> hRData[31:4] == 28'd0);

  a_r3_enable_bit25_moved: assert property (@(posedge clk) disable iff (!rstN)
    (vWe && (vAddr == AW'(8'h34) || vAddr == AW'(8'h38))) |-> !vWData[25]);

  a_r5_xfermode_no_vendor: assert property (@(posedge clk) disable iff (!rstN)
    (hReq && hReady && hWe && hAddr == AW'(8'h0C) && hSize == 2'd1) |=> (!vRe && !vWe));

  a_r12_rmw_same_word: assert property (@(posedge clk) disable iff (!rstN)
    (vWe && $past(vRe)) |-> vAddr == $past(vAddr));
endmodule

bind sd_reg_shim sd_reg_shim_chk #(.AW(AW)) u_chk (
  .clk(clk), .rstN(rstN), .hReq(hReq), .hWe(hWe), .hAddr(hAddr), .hSize(hSize),
  .hReady(hReady), .hRValid(hRValid), .hRData(hRData), .vRe(vRe), .vWe(vWe),
  .vAddr(vAddr), .vWData(vWData)
);

// File: tb/sd_reg_shim_bench.sv
module sd_reg_shim_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hReq = 1'b0, hWe = 1'b0;
  logic [7:0]  hAddr = '0;
  logic [1:0]  hSize = '0;
  logic [31:0] hWData = '0;
  logic        hReady, hRValid, vRe, vWe;
  logic [31:0] hRData, vWData, vRData;
  logic [7:0]  vAddr;
  logic [31:0] mem [64];
  int          checks = 0, fails = 0, cycles = 0;
  logic [31:0] expQ [$];
  string       tagQ [$];

  always #2.5 clk = ~clk;

  sd_reg_shim u_sd_reg_shim (
    .clk(clk), .rstN(rstN), .hReq(hReq), .hWe(hWe), .hAddr(hAddr), .hSize(hSize),
    .hWData(hWData), .hReady(hReady), .hRValid(hRValid), .hRData(hRData),
    .vRe(vRe), .vWe(vWe), .vAddr(vAddr), .vWData(vWData), .vRData(vRData)
  );

  assign vRData = mem[vAddr[7:2]];
  always @(posedge clk) if (vWe) mem[vAddr[7:2]] <= vWData;

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data as responses appear
  always @(negedge clk) begin
    if (rstN && hRValid) begin
      if (expQ.size() == 0) check(hRData, 32'hxxxx_xxxx, "R13 unexpected response");
      else check(hRData, expQ.pop_front(), tagQ.pop_front());
    end
  end

  task automatic access(input logic we, input logic [7:0] addr, input logic [1:0] size,
                        input logic [31:0] data, input int expBusy, input string tag);
    int busy = 0;
    while (!hReady) @(negedge clk);
    hReq = 1'b1; hWe = we; hAddr = addr; hSize = size; hWData = data;
    @(negedge clk);
    hReq = 1'b0;
    while (!hReady) begin busy++; @(negedge clk); end
    check(32'(busy), 32'(expBusy), {"R13 busy cycles ", tag});
  endtask

  task automatic rd(input logic [7:0] addr, input logic [1:0] size,
                    input logic [31:0] exp, input string tag);
    expQ.push_back(exp); tagQ.push_back(tag);
    access(1'b0, addr, size, 32'h0, 1, tag);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 50000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected <50000 cycles", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check({31'b0, hReady}, 32'd1, "R13 reset ready");
    check({31'b0, hRValid}, 32'd0, "R13 reset no response");

    // R12 pass-through and lanes
    access(1'b1, 8'h50, 2'd2, 32'hA5A5_1234, 1, "R12 word write");
    check(mem[20], 32'hA5A5_1234, "R12 word stored");
    rd(8'h50, 2'd2, 32'hA5A5_1234, "R12 word read");
    access(1'b1, 8'h51, 2'd0, 32'h7E, 2, "R12 byte write");
    check(mem[20], 32'hA5A5_7E34, "R12 byte lane1");
    access(1'b1, 8'h52, 2'd1, 32'hBEEF, 2, "R12 half write");
    check(mem[20], 32'hBEEF_7E34, "R12 half lane2");
    rd(8'h53, 2'd0, 32'h0000_00BE, "R12 byte read lane3");
    rd(8'h52, 2'd1, 32'h0000_BEEF, "R12 half read");

    // R1 present state
    mem[9] = 32'h0F8A_BCDE;
    rd(8'h24, 2'd2, 32'h01FA_BCDE, "R1 present remap a");
    mem[9] = 32'hF071_2345;
    rd(8'h24, 2'd2, 32'h0001_2345, "R1 present remap b");

    // R2 interrupt status
    mem[12] = 32'h1000_0001;
    rd(8'h30, 2'd2, 32'h0200_0001, "R2 dma error moved");
    mem[12] = 32'h0200_0004;
    rd(8'h30, 2'd2, 32'h0200_0004, "R2 no dma error");

    // R4 capabilities
    mem[16] = 32'h0010_0001;
    rd(8'h40, 2'd2, 32'h0008_0001, "R4 adma1 to adma2");
    mem[16] = 32'h0008_0000;
    rd(8'h40, 2'd2, 32'h0008_0000, "R4 unchanged");

    // R3 enable writes
    access(1'b1, 8'h34, 2'd2, 32'h0200_0003, 1, "R3 int enable");
    check(mem[13], 32'h1000_0003, "R3 int enable remap");
    access(1'b1, 8'h38, 2'd2, 32'h0000_0005, 1, "R3 signal enable");
    check(mem[14], 32'h0000_0005, "R3 signal enable plain");

    // R5 / R6 deferred transfer mode
    mem[3] = 32'hDEAD_BEEF;
    access(1'b1, 8'h0C, 2'd1, 32'h0023, 0, "R5 xfer mode held");
    check(mem[3], 32'hDEAD_BEEF, "R5 vendor untouched");
    access(1'b1, 8'h0E, 2'd1, 32'h0C3A, 1, "R6 command");
    check(mem[3], 32'h0C3A_0023, "R6 merged word");
    access(1'b1, 8'h0E, 2'd1, 32'h1111, 1, "R6 command again");
    check(mem[3], 32'h1111_0023, "R6 scratch reused");

    // R7 clock control
    mem[48] = 32'h0000_0002;
    mem[11] = 32'h1234_5678;
    access(1'b1, 8'h2C, 2'd1, 32'h0004, 2, "R7 clock on");
    check(mem[48], 32'h0000_0102, "R7 force clock set");
    check(mem[11], 32'h1234_5678, "R7 system word untouched");
    access(1'b1, 8'h2C, 2'd1, 32'h0001, 2, "R7 clock off");
    check(mem[48], 32'h0000_0002, "R7 force clock clear");

    // R8 host control 2
    mem[15] = 32'hAAAA_5555;
    access(1'b1, 8'h3E, 2'd1, 32'h8002, 2, "R8 write a");
    check(mem[48], 32'h0000_0000, "R8 select low");
    rd(8'h3E, 2'd1, 32'h0000_0002, "R8 read a");
    access(1'b1, 8'h3E, 2'd1, 32'h800D, 2, "R8 write b");
    check(mem[48], 32'h0000_0002, "R8 select high");
    rd(8'h3E, 2'd1, 32'h0000_000D, "R8 read b preset zero");
    check(mem[15], 32'hAAAA_5555, "R8 standard word untouched");

    // R9 block size
    access(1'b1, 8'h04, 2'd1, 32'hFFFF, 2, "R9 block size");
    check(mem[1], 32'h0000_8FFF, "R9 bits 14:12 cleared");
    access(1'b1, 8'h06, 2'd1, 32'h0003, 2, "R12 block count");
    check(mem[1], 32'h0003_8FFF, "R12 upper half RMW");

    // R11 host control byte
    mem[10] = 32'h0000_000E;
    access(1'b1, 8'h28, 2'd0, 32'hFF, 2, "R11 host ctl a");
    check(mem[10], 32'h0000_030F, "R11 width kept dma shifted");
    mem[10] = 32'hABCD_0000;
    access(1'b1, 8'h28, 2'd0, 32'h08, 2, "R11 host ctl b");
    check(mem[10], 32'hABCD_0100, "R11 upper kept");

    // R10 software reset
    mem[11] = 32'h0000_0010;
    access(1'b1, 8'h2F, 2'd0, 32'h01, 2, "R10 reset all");
    check(mem[11], 32'h0100_0017, "R10 clocks forced");
    mem[11] = 32'h0000_0010;
    access(1'b1, 8'h2F, 2'd0, 32'h02, 2, "R10 reset other");
    check(mem[11], 32'h0200_0010, "R10 no force");

    repeat (3) @(negedge clk);
    check(32'(expQ.size()), 32'd0, "R13 all responses seen");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule